// File: doc/BRIEF.md
# Mantissa Normalizer with Leading-Zero Count

This block is the normalization step that follows a mantissa adder in a floating-point datapath. It accepts a 25-bit unnormalized mantissa. Bit 24 may carry the overflow of the preceding add, and bit 23 is the hidden-one position. The block locates the most significant one and returns a 24-bit mantissa with that one in the top bit.

It also returns the number of zeros above the first one, a signed exponent correction for the exponent stage that follows, and a flag for an all-zero input. The block has no clock and no state: every output is a pure function of the present input. Rounding, sticky bits, exponent arithmetic and special operands are handled elsewhere.

A carry in bit 24 makes the block shift right by one, dropping input bit 0. Otherwise it shifts left by one less than the zero count. The count comes from a balanced priority-encoder tree, and a logarithmic shifter driven by the count bits moves the data.

Top module: `mantNormTop`

## Requirements
- R1: `lzCount` equals the number of zero bits scanned from input bit 24 downward before the first one, in the range 0 to 25 (unsigned, 5 bits).
- R2: When input bit 24 is 1, `normOut` equals input bits 24..1 (a right shift by one that discards bit 0), and `expAdj` is +1.
- R3: When input bit 24 is 0 and bit 23 is 1, `normOut` equals input bits 23..0 unchanged, and `expAdj` is 0.
- R4: When the first one is at bit p with p at most 22, `normOut` equals input bits p..0 followed by 23-p zero bits, so that the one sits in `normOut` bit 23.
- R5: For an all-zero input, `lzCount` is 25, `isZero` is 1, `normOut` is all zeros and `expAdj` is -24.
- R6: For any nonzero input, `isZero` is 0 and `normOut` bit 23 is 1.
- R7: `expAdj` is the 6-bit two's-complement value of 1 minus `lzCount`.
- R8: The block is combinational: all outputs reflect a new input within the same cycle, and no clock or reset is involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mantIn | input | 25 | Unnormalized mantissa; bit 24 is the carry position, bit 23 the hidden-one position |
| normOut | output | 24 | Normalized mantissa with the leading one in bit 23 |
| lzCount | output | 5 | Zeros above the first one, 0 to 25 |
| expAdj | output | 6 | Signed exponent correction, 1 minus `lzCount` |
| isZero | output | 1 | High when the input has no set bit |

## Verification
The bench first tries a single one at each of the 25 positions. This separates a wrong count, or a wrong shift stage, at each individual position. It then tries, for each position, that one with every lower bit set. This shows whether low bits are dropped or misplaced on the way through the shifter, and whether the right-shift path discards exactly bit 0.

The all-zero and all-ones inputs pin down the two ends of the count range. Random vectors, thinned to random lengths so that every leading position is reached, mix the count bits in combinations that the structured patterns do not cover.

// File: rtl/normPkg.sv
package normPkg;
  // Width of the unnormalized mantissa, including the carry bit.
  parameter int unsigned MANT_W = 25;
  // Width of the normalized mantissa.
  localparam int unsigned OUT_W = MANT_W - 1;
  // Bits needed to hold a count from 0 to MANT_W.
  localparam int unsigned CNT_W = $clog2(MANT_W + 1);
  // Signed exponent correction width: one extra bit for the sign.
  localparam int unsigned ADJ_W = CNT_W + 1;
  // The encoder tree works on a power-of-two vector.
  localparam int unsigned TREE_W = 1 << CNT_W;

  // Strobes passed from the count logic to the shifting datapath.
  typedef struct packed {
    logic             shiftRight;
    logic             allZero;
    logic [CNT_W-1:0] leftAmt;
  } normCtl_t;

  function automatic int floorLog2(input int v);
    int r;
    r = 0;
    while ((v >> (r + 1)) > 0) r++;
    return r;
  endfunction
endpackage

// File: rtl/normCount.sv
module normCount
  import normPkg::*;
(
  input  logic [MANT_W-1:0]       mantIn,
  output logic [CNT_W-1:0]        zeroCnt,
  output logic signed [ADJ_W-1:0] adjOut,
  output normCtl_t                ctl
);
  // Padded vector: the mantissa, then a single marker one, then zeros.
  // On an all-zero mantissa the marker stops the scan at MANT_W.
  logic [TREE_W-1:0] padded;
  always_comb begin
    padded = '0;
    padded[TREE_W-1 -: MANT_W] = mantIn;
    padded[TREE_W-1-MANT_W]    = 1'b1;
  end

  // Heap-ordered tree: node i has children 2i (more significant) and 2i+1.
  logic             nodeVal [1:2*TREE_W-1];
  logic [CNT_W-1:0] nodeCnt [1:2*TREE_W-1];

  for (genvar k = 0; k < TREE_W; k++) begin : g_leaf
    assign nodeVal[TREE_W+k] = padded[TREE_W-1-k];
    assign nodeCnt[TREE_W+k] = '0;
  end

  for (genvar i = 1; i < TREE_W; i++) begin : g_node
    localparam int H = CNT_W - floorLog2(i);
    assign nodeVal[i] = nodeVal[2*i] | nodeVal[2*i+1];
    assign nodeCnt[i] = nodeVal[2*i] ? nodeCnt[2*i]
                                     : (nodeCnt[2*i+1] | CNT_W'(1 << (H - 1)));
  end

  assign zeroCnt = nodeCnt[1];

  always_comb begin
    ctl.shiftRight = (zeroCnt == '0);
    ctl.allZero    = (zeroCnt == CNT_W'(MANT_W));
    ctl.leftAmt    = ctl.shiftRight ? '0 : zeroCnt - CNT_W'(1);
    adjOut         = $signed(ADJ_W'(1)) - $signed({1'b0, zeroCnt});
  end

  always_comb begin
    // R1: the marker guarantees that a one is always found
    a_r1_root_found: assert (nodeVal[1]);
    // R5: an all-zero input and the full count go together
    a_r5_zero_count: assert ((mantIn == '0) == (zeroCnt == CNT_W'(MANT_W)));
    // R2: a zero count happens only when the carry bit is set
    a_r2_carry_count: assert (mantIn[MANT_W-1] == (zeroCnt == '0));
  end
endmodule

// File: rtl/normShift.sv
module normShift
  import normPkg::*;
(
  input  logic [MANT_W-1:0] mantIn,
  input  normCtl_t          ctl,
  output logic [OUT_W-1:0]  normOut
);
  logic [OUT_W-1:0] stg [0:CNT_W];

  // Choose between the right-shift-by-one and the left-aligned source.
  assign stg[0] = ctl.shiftRight ? mantIn[MANT_W-1:1] : mantIn[OUT_W-1:0];

  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    assign stg[s+1] = ctl.leftAmt[s] ? (stg[s] << (1 << s)) : stg[s];
  end

  assign normOut = ctl.allZero ? '0 : stg[CNT_W];

  always_comb begin
    // R6: any nonzero input ends with the leading one in the top bit
    if (!ctl.allZero) a_r6_top_set: assert (normOut[OUT_W-1]);
    // R5: the all-zero case leaves no bit set
    if (ctl.allZero) a_r5_out_clear: assert (normOut == '0);
  end
endmodule

// File: rtl/mantNormTop.sv
module mantNormTop
  import normPkg::*;
(
  input  logic [24:0]        mantIn,
  output logic [23:0]        normOut,
  output logic [4:0]         lzCount,
  output logic signed [5:0]  expAdj,
  output logic               isZero
);
  normCtl_t ctl;

  normCount u_count (
    .mantIn (mantIn),
    .zeroCnt(lzCount),
    .adjOut (expAdj),
    .ctl    (ctl)
  );

  normShift u_shift (
    .mantIn (mantIn),
    .ctl    (ctl),
    .normOut(normOut)
  );

  assign isZero = ctl.allZero;

  always_comb begin
    // R2: a carry gives a correction of +1
    if (mantIn[24]) a_r2_adj_plus: assert (expAdj == 6'sd1);
    // R3: an input already aligned passes through unchanged
    if (!mantIn[24] && mantIn[23]) a_r3_pass: assert (normOut == mantIn[23:0] && expAdj == 6'sd0);
    // R7: the correction never exceeds +1
    a_r7_adj_range: assert (expAdj <= 6'sd1 && expAdj >= -6'sd24);
  end
endmodule

// File: tb/mantNormTop_bench.sv
module mantNormTop_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;  // 100 MHz

  logic [24:0]       mantIn = '0;
  logic [23:0]       normOut;
  logic [4:0]        lzCount;
  logic signed [5:0] expAdj;
  logic              isZero;

  mantNormTop u_mantNormTop (
    .mantIn(mantIn), .normOut(normOut), .lzCount(lzCount),
    .expAdj(expAdj), .isZero(isZero)
  );

  typedef struct packed {
    logic [24:0]       din;
    logic [23:0]       dout;
    logic [4:0]        cnt;
    logic signed [5:0] adj;
    logic              zero;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit driverDone = 0;

  // Behavioural reference: serial scan, then a plain shift.
  function automatic item_t refModel(input logic [24:0] m);
    item_t r;
    int c;
    c = 25;
    for (int i = 24; i >= 0; i--)
      if (m[i] && c == 25) c = 24 - i;
    r.din  = m;
    r.cnt  = 5'(c);
    r.adj  = 6'(1 - c);
    r.zero = (c == 25);
    if (c == 0)       r.dout = m[24:1];
    else if (c == 25) r.dout = '0;
    else              r.dout = m[23:0] << (c - 1);
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input logic [24:0] din);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s in=%h actual=%h expected=%h", tag, din, act, exp);
    end
  endtask

  task automatic drive(input logic [24:0] v);
    @(posedge clk);
    mantIn = v;
    expQ.push_back(refModel(v));
  endtask

  // Monitor: half a cycle after each drive, with no clock in the design (R8).
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        item_t e;
        string outTag;
        e = expQ.pop_front();
        if (e.din == '0)     outTag = "R5 out";
        else if (e.din[24])  outTag = "R2 out";
        else if (e.din[23])  outTag = "R3 out";
        else                 outTag = "R4 out";
        check("R1 count", 32'(lzCount), 32'(e.cnt), e.din);
        check(outTag, 32'(normOut), 32'(e.dout), e.din);
        check("R7 adj", 32'(expAdj), 32'(e.adj), e.din);
        check(e.zero ? "R5 zero" : "R6 zero", 32'(isZero), 32'(e.zero), e.din);
        if (!e.zero) check("R6 top bit", 32'(normOut[23]), 32'd1, e.din);
        // R8: outputs already settled in the cycle the input changed
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // Power-up state with zero input (R5).
    #2;
    check("R5 initial count", 32'(lzCount), 32'd25, mantIn);
    check("R5 initial zero", 32'(isZero), 32'd1, mantIn);
    check("R5 initial out", 32'(normOut), 32'd0, mantIn);
    // R1/R4: a single one at every position.
    for (int p = 0; p < 25; p++) drive(25'(1) << p);
    // R4: the leading one with every lower bit set.
    for (int p = 0; p < 25; p++) drive((25'(1) << (p + 1)) - 25'(1));
    drive('0);           // R5
    drive('1);           // R2
    drive(25'h0800001);  // R3 with bit 0 set
    drive(25'h1000001);  // R2 drops bit 0
    for (int n = 0; n < 300; n++) begin
      logic [24:0] v;
      v = 25'($urandom) >> ($urandom % 26);
      drive(v);
    end
    @(posedge clk);
    @(posedge clk);
    driverDone = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule